// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the header portion of a LIN master frame onto a serial transmit line. A one-cycle start strobe launches the header. The block then holds the line low for a programmable break. A programmable high delimiter follows. After that come, depending on a select code, nothing more, the sync character, or the sync character followed by the protected identifier. A one-cycle done pulse marks the end.

Bit timing comes entirely from an external bit-rate tick. One bit time is the span between two consecutive ticks, and every bit boundary falls in the cycle after a tick. Configuration is captured when the start strobe is accepted. Changes to the inputs during a header therefore have no effect. A start strobe that arrives while a header is running is dropped.

Top module: `lin_hdr_gen`

## Requirements
- R1: After reset and while idle, `tx_o` is high and `done_o` is low.
- R2: The break drives `tx_o` low for `brk_len_i`+1 bit times, where `brk_len_i` holds the break length minus one (valid 9..14, i.e. 10..15 bits). The first break bit begins in the cycle after the start strobe is accepted.
- R3: A `brk_len_i` value below 9 acts as 9, and a value above 14 acts as 14.
- R4: The delimiter after the break drives `tx_o` high for `dlm_len_i`+1 bit times, where `dlm_len_i` holds the length minus one (1..4 bits).
- R5: `sel_i` = 0 sends break and delimiter only. `sel_i` = 1 adds the sync character. `sel_i` = 2 or 3 adds the sync character and then the identifier character.
- R6: Each character is one low start bit, then eight data bits LSB first, then one high stop bit. The sync character carries 0x55.
- R7: With `par_en_i` = 1, the identifier byte is `id_i[5:0]` in bits 5:0. Bit 6 is id0^id1^id2^id4, and bit 7 is the inverse of id1^id3^id4^id5.
- R8: With `par_en_i` = 0, the identifier byte is `id_i[7:0]` unchanged.
- R9: `done_o` is high for exactly one cycle, in the cycle after the tick that ends the final stop bit (for code 0, the final delimiter bit). The line is high from that cycle on.
- R10: A start strobe during a header is ignored. No second header and no extra done pulse follow. Input changes during a header do not alter it.
- R11: `tx_o` changes only in the cycle after a tick, or in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate tick, one cycle per bit time |
| start_i | input | 1 | Send-header strobe |
| sel_i | input | 2 | Header field select code |
| brk_len_i | input | 4 | Break length minus one |
| dlm_len_i | input | 2 | Delimiter length minus one |
| id_i | input | 8 | Frame identifier (bits 7:6 used raw when parity is off) |
| par_en_i | input | 1 | Identifier parity insertion enable |
| tx_o | output | 1 | Serial transmit line |
| done_o | output | 1 | Header complete pulse |

## Verification
The bench rebuilds the line waveform one bit per tick and compares it with a header built from the requirements. It covers every select code, both ends of the break and delimiter ranges, and out-of-range break values. A design with an off-by-one counter load would show one bit too many or too few in the break or delimiter. A design with a wrong parity term would corrupt bits 6 and 7 of the identifier. A design that reversed the data order would fail on the 0x55 and 0xC5 patterns. The bench also sends a second strobe with different settings in the middle of a header. A design that did not lock its configuration, or that re-armed itself, would show a changed waveform, a second break, or an extra done pulse.

// File: rtl/lin_hdr_pkg.sv
`timescale 1ns/1ps
package lin_hdr_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam logic [DATA_W-1:0] SYNC_BYTE = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DLM,
    ST_SYNC,
    ST_PID
  } hdr_state_e;
endpackage

// File: rtl/lin_hdr_pid.sv
`timescale 1ns/1ps
module lin_hdr_pid
  import lin_hdr_pkg::*;
(
  input  logic [DATA_W-1:0] id_i,
  input  logic              par_en_i,
  output logic [DATA_W-1:0] pid_o
);
  logic p0, p1;

  always_comb begin
    p0 = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
    p1 = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
    if (par_en_i) pid_o = {p1, p0, id_i[5:0]};
    else          pid_o = id_i;
  end
endmodule

// File: rtl/lin_hdr_cfg.sv
`timescale 1ns/1ps
module lin_hdr_cfg
  import lin_hdr_pkg::*;
#(
  parameter int unsigned DLM_W = 2,
  parameter int unsigned SEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DLM_W-1:0]  dlm_i,
  input  logic [DATA_W-1:0] pid_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DLM_W-1:0]  dlm_o,
  output logic [DATA_W-1:0] pid_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [DLM_W-1:0]  dlm_q;
  logic [DATA_W-1:0] pid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      dlm_q <= '0;
      pid_q <= '0;
    end else if (load_i) begin
      sel_q <= sel_i;
      dlm_q <= dlm_i;
      pid_q <= pid_i;
    end
  end

  assign sel_o = sel_q;
  assign dlm_o = dlm_q;
  assign pid_o = pid_q;

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(pid_q) && $stable(sel_q) && $stable(dlm_q)));

  // R10
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_i);
endmodule

// File: rtl/lin_hdr_seq.sv
`timescale 1ns/1ps
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int unsigned BRK_W   = 4,
  parameter int unsigned DLM_W   = 2,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned BRK_MIN = 9,
  parameter int unsigned BRK_MAX = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [BRK_W-1:0]  brk_len_i,
  input  logic [DLM_W-1:0]  dlm_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] pid_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              tx_o,
  output logic              done_o
);
  localparam int unsigned FRM_CW = $clog2(FRAME_W);
  localparam int unsigned CNT_W  = (BRK_W > FRM_CW) ? BRK_W : FRM_CW;
  localparam logic [BRK_W-1:0] BRK_LO   = BRK_W'(BRK_MIN);
  localparam logic [BRK_W-1:0] BRK_HI   = BRK_W'(BRK_MAX);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  hdr_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               tx_q, tx_d;
  logic               done_q, done_d;
  logic [BRK_W-1:0]   brk_eff;
  logic               cnt_zero;

  // out-of-range break codes are pinned to the legal window
  always_comb begin
    if (brk_len_i < BRK_LO)      brk_eff = BRK_LO;
    else if (brk_len_i > BRK_HI) brk_eff = BRK_HI;
    else                         brk_eff = brk_len_i;
  end

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    frame_d = frame_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_BRK;
          cnt_d   = CNT_W'(brk_eff);
        end
      end
      ST_BRK: begin
        if (tick_i) begin
          if (cnt_zero) begin
            state_d = ST_DLM;
            cnt_d   = CNT_W'(dlm_i);
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
      end
      ST_DLM: begin
        if (tick_i) begin
          if (!cnt_zero) begin
            cnt_d = cnt_q - CNT_ONE;
          end else if (sel_i == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_SYNC;
            frame_d = {1'b1, SYNC_BYTE, 1'b0};
            cnt_d   = FRM_LAST;
          end
        end
      end
      ST_SYNC, ST_PID: begin
        if (tick_i) begin
          frame_d = {1'b1, frame_q[FRAME_W-1:1]};
          if (!cnt_zero) begin
            cnt_d = cnt_q - CNT_ONE;
          end else if (state_q == ST_SYNC && sel_i[1]) begin
            state_d = ST_PID;
            frame_d = {1'b1, pid_i, 1'b0};
            cnt_d   = FRM_LAST;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // line level taken from next state so tx_o comes straight off a flop
  always_comb begin
    unique case (state_d)
      ST_IDLE: tx_d = 1'b1;
      ST_BRK:  tx_d = 1'b0;
      ST_DLM:  tx_d = 1'b1;
      default: tx_d = frame_d[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      frame_q <= '1;
      tx_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
      tx_q    <= tx_d;
      done_q  <= done_d;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign busy_o = (state_q != ST_IDLE);
  assign tx_o   = tx_q;
  assign done_o = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(tick_i) && tx_o && !busy_o));

  // R11
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(start_i)) |-> $stable(tx_o));

  // R3
  brk_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK) |-> (cnt_q <= CNT_W'(BRK_MAX)));

  // R2
  brk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK) |-> !tx_o);

  // R1
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> tx_o);
endmodule

// File: rtl/lin_hdr_gen.sv
`timescale 1ns/1ps
module lin_hdr_gen
  import lin_hdr_pkg::*;
#(
  parameter int unsigned BRK_W   = 4,
  parameter int unsigned DLM_W   = 2,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned BRK_MIN = 9,
  parameter int unsigned BRK_MAX = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BRK_W-1:0]  brk_len_i,
  input  logic [DLM_W-1:0]  dlm_len_i,
  input  logic [DATA_W-1:0] id_i,
  input  logic              par_en_i,
  output logic              tx_o,
  output logic              done_o
);
  logic              load, busy;
  logic [DATA_W-1:0] pid_raw, pid_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DLM_W-1:0]  dlm_q;

  lin_hdr_pid u_pid (
    .id_i     (id_i),
    .par_en_i (par_en_i),
    .pid_o    (pid_raw)
  );

  lin_hdr_cfg #(.DLM_W(DLM_W), .SEL_W(SEL_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .busy_i (busy),
    .sel_i  (sel_i),
    .dlm_i  (dlm_len_i),
    .pid_i  (pid_raw),
    .sel_o  (sel_q),
    .dlm_o  (dlm_q),
    .pid_o  (pid_q)
  );

  lin_hdr_seq #(
    .BRK_W(BRK_W), .DLM_W(DLM_W), .SEL_W(SEL_W),
    .BRK_MIN(BRK_MIN), .BRK_MAX(BRK_MAX)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .brk_len_i (brk_len_i),
    .dlm_i     (dlm_q),
    .sel_i     (sel_q),
    .pid_i     (pid_q),
    .load_o    (load),
    .busy_o    (busy),
    .tx_o      (tx_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/lin_hdr_gen_bench.sv
`timescale 1ns/1ps
module lin_hdr_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] sel_i = '0;
  logic [3:0] brk_len_i = 4'd11;
  logic [1:0] dlm_len_i = '0;
  logic [7:0] id_i = '0;
  logic       par_en_i = 1'b0;
  logic       tx_o, done_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  lin_hdr_gen u_lin_hdr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .sel_i(sel_i), .brk_len_i(brk_len_i), .dlm_len_i(dlm_len_i),
    .id_i(id_i), .par_en_i(par_en_i), .tx_o(tx_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // one tick every 4 cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  function automatic logic [7:0] exp_pid(input logic [7:0] id, input bit pen);
    logic a, b;
    a = id[0] ^ id[1] ^ id[2] ^ id[4];
    b = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return pen ? {b, a, id[5:0]} : id;
  endfunction

  task automatic push_char(ref bit q[$], input logic [7:0] b);
    q.push_back(1'b0);
    for (int i = 0; i < 8; i++) q.push_back(b[i]);
    q.push_back(1'b1);
  endtask

  task automatic run_hdr(input string req, input logic [1:0] sel,
                         input logic [3:0] brk, input logic [1:0] dlm,
                         input logic [7:0] id, input bit pen, input int inject);
    bit exp_q[$];
    bit got_q[$];
    int brk_n, cyc, mism, first_bad, hold_bad;
    bit prev_valid, prev_tick, prev_tx, inj_done, inj_on;
    brk_n = (brk < 9) ? 9 : ((brk > 14) ? 14 : int'(brk));
    for (int i = 0; i <= brk_n; i++) exp_q.push_back(1'b0);
    for (int i = 0; i <= int'(dlm); i++) exp_q.push_back(1'b1);
    if (sel != 2'd0) push_char(exp_q, 8'h55);
    if (sel[1]) push_char(exp_q, exp_pid(id, pen));

    @(negedge clk_i);
    sel_i = sel; brk_len_i = brk; dlm_len_i = dlm; id_i = id; par_en_i = pen;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0; hold_bad = 0; prev_valid = 1'b0; inj_done = 1'b0; inj_on = 1'b0;
    while (!done_o && cyc < 4000) begin
      if (inj_on) begin
        start_i = 1'b0;
        inj_on = 1'b0;
      end else if (inject >= 0 && !inj_done && got_q.size() == inject) begin
        start_i = 1'b1; sel_i = 2'd0; brk_len_i = 4'd3; dlm_len_i = ~dlm;
        id_i = ~id; par_en_i = ~pen;
        inj_done = 1'b1; inj_on = 1'b1;
      end
      if (prev_valid && !prev_tick && tx_o != prev_tx) hold_bad++;
      if (tick_i) got_q.push_back(tx_o);
      prev_valid = 1'b1; prev_tick = tick_i; prev_tx = tx_o;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, req, "done seen (R9)", int'(done_o), 1);
    chk(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, req, "first mismatching bit index", first_bad, -1);
    chk(hold_bad == 0, req, "tx change between ticks (R11)", hold_bad, 0);
    chk(tx_o == 1'b1, req, "line high at done (R9)", int'(tx_o), 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, req, "done one cycle (R9)", int'(done_o), 0);
    if (inject >= 0) begin
      int extra = 0;
      int low = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk_i);
        if (done_o) extra++;
        if (!tx_o) low++;
      end
      chk(extra == 0 && low == 0, req, "activity after header (R10)", extra + low, 0);
    end
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    // R1 during reset
    chk(tx_o == 1'b1 && done_o == 1'b0, "R1", "reset outputs", {tx_o, done_o}, 2);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(tx_o == 1'b1 && done_o == 1'b0, "R1", "idle outputs", {tx_o, done_o}, 2);

    run_hdr("R2 R4 R5 R9 code0",  2'd0, 4'd11, 2'd0, 8'h00, 1'b0, -1);
    run_hdr("R4 R5 R6 R11 code1", 2'd1, 4'd9,  2'd3, 8'h00, 1'b0, -1);
    run_hdr("R5 R6 R7 code2",     2'd2, 4'd14, 2'd1, 8'h3C, 1'b1, -1);
    run_hdr("R7 id zero",         2'd2, 4'd12, 2'd2, 8'h00, 1'b1, -1);
    run_hdr("R7 id 0x2B",         2'd2, 4'd10, 2'd0, 8'hEB, 1'b1, -1);
    run_hdr("R8 raw id",          2'd2, 4'd10, 2'd0, 8'hC5, 1'b0, -1);
    run_hdr("R3 clamp low",       2'd1, 4'd2,  2'd0, 8'h00, 1'b0, -1);
    run_hdr("R3 clamp high",      2'd0, 4'd15, 2'd1, 8'h00, 1'b0, -1);
    run_hdr("R5 code3",           2'd3, 4'd11, 2'd1, 8'h2A, 1'b1, -1);
    run_hdr("R10 start in break", 2'd2, 4'd11, 2'd1, 8'h11, 1'b1, 6);
    run_hdr("R10 start in id",    2'd2, 4'd9,  2'd0, 8'h07, 1'b0, 27);

    summary();
    $finish;
  end
endmodule